// File: doc/BRIEF.md
# Clocked Serial Shift Controller

This block runs an eight-bit synchronous serial port. It receives the bit clock from a pin or makes the bit clock itself by dividing the system clock. Software arms the port with a start strobe. The bit counter then follows one byte through eight rising edges of the bit clock. At the end of the byte, the received byte appears on the parallel output and a sticky interrupt flag is raised. The port does not take another byte until software issues a new start strobe.

Bits leave most-significant first. The outgoing bit changes on the falling edge of the bit clock, and the incoming bit is sampled on the rising edge. A write strobe to the mode register stops the port at any point. If a byte was in flight, the write raises the flag. In internal-clock mode, the same write can instead put the port into a free-running clock output state.

Software misuse also raises the flag: a start strobe that arrives while a byte is in flight sets it.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset the block waits for a start strobe. In this state `irq_o`=0, `data_o`=0, `sdo_o`=0 and `sclk_o`=1.
- R2: While the block waits for a start strobe, bit-clock edges have no effect. The flag and the received byte keep their values.
- R3: A start strobe arms the port. The next eight rising bit-clock edges shift one byte in, with the first bit received landing in bit 7. The byte then appears on `data_o` and `irq_o` is set.
- R4: Before the first rising edge, `sdo_o` carries bit 7 of the loaded byte. Each falling edge inside the byte moves `sdo_o` to the next lower bit.
- R5: Once a byte has completed, bit-clock edges are ignored until another start strobe re-arms the port.
- R6: A start strobe that arrives while a byte is in flight sets `irq_o`.
- R7: A mode-register write aborts any state and returns the block to waiting for a start strobe, with the bit counter at zero. The write sets `irq_o` if a byte was in flight.
- R8: `irq_o` stays set until an `irq_clr_i` pulse clears it. A set event in the same cycle takes priority over the clear.
- R9: A write to the parallel data register while a byte is in flight is ignored.
- R10: In internal-clock mode (`ext_clk_sel_i`=0), an armed byte produces exactly eight rising edges on `sclk_o`. Each half period lasts DIV system clocks. `sclk_o` rests high at all other times.
- R11: A mode-register write with internal clock selected and `cont_clk_sel_i`=1 starts a free-running `sclk_o` that sets no flag. A later mode-register write with `cont_clk_sel_i`=0 stops the clock with `sclk_o` high.
- R12: In external-clock mode, `sclk_o` stays high. `sclk_ext_i` passes through a two-flop synchronizer before its edges are detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-command strobe |
| mode_wr_i | input | 1 | Mode-register write strobe |
| ext_clk_sel_i | input | 1 | 1: bit clock from `sclk_ext_i`; 0: internal divider |
| cont_clk_sel_i | input | 1 | Free-running clock request, taken on a mode write |
| sclk_ext_i | input | 1 | External bit clock |
| sclk_o | output | 1 | Generated bit clock, idle high |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| data_wr_i | input | 1 | Parallel data register write strobe |
| data_i | input | W | Byte to transmit |
| data_o | output | W | Last received byte |
| irq_o | output | 1 | Sticky transfer interrupt flag |
| irq_clr_i | input | 1 | Flag clear strobe |

## Verification
Strobes act on the next clock edge, so the flag for a start or abort inside a byte can be read one cycle later. An external clock edge takes three system cycles to pass through the synchronizer and edge detector. An internal edge arrives DIV cycles after the previous one. The bench holds each external clock level for six cycles and samples outputs only after that settling window. It waits several full byte times before it checks the results of internal-clock runs. Every expected value is queued at the moment of sampling and compared on the following falling system-clock edge, when all registers are stable.

// File: rtl/ssp_ctrl.sv
module ssp_ctrl #(
  parameter int W   = 8,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         mode_wr_i,
  input  logic         ext_clk_sel_i,
  input  logic         cont_clk_sel_i,
  input  logic         sclk_ext_i,
  output logic         sclk_o,
  input  logic         sdi_i,
  output logic         sdo_o,
  input  logic         data_wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic         irq_o,
  input  logic         irq_clr_i
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  typedef enum logic [1:0] {ST_WSTART = 2'd0, ST_WCLK = 2'd1, ST_XFER = 2'd2, ST_CONT = 2'd3} st_t;

  st_t          st_q;
  logic [CW-1:0] cnt_q;
  logic         armed_q, irq_q, sdo_q, sclk_int_q;
  logic [W-1:0] shreg_q, rx_q;
  logic [DW-1:0] div_q;
  logic [2:0]   ex_s;
  logic [1:0]   sdi_s;

  logic run, tick, rise_ev, fall_ev, count_rise, wrap_ev, in_xfer, wr_ok;

  assign in_xfer = (st_q == ST_XFER);
  assign run     = !ext_clk_sel_i &&
                   (in_xfer || st_q == ST_CONT || (st_q == ST_WCLK && armed_q));
  assign tick    = run && (div_q == DW'(DIV - 1));
  assign rise_ev = ext_clk_sel_i ? (ex_s[1] & ~ex_s[2]) : (tick & ~sclk_int_q);
  assign fall_ev = ext_clk_sel_i ? (~ex_s[1] & ex_s[2]) : (tick & sclk_int_q);
  assign count_rise = rise_ev && !mode_wr_i && (in_xfer || (st_q == ST_WCLK && armed_q));
  assign wrap_ev = count_rise && in_xfer && (cnt_q == CW'(W - 1));
  assign wr_ok   = data_wr_i && !in_xfer;

  assign sclk_o = ext_clk_sel_i ? 1'b1 : sclk_int_q;
  assign sdo_o  = sdo_q;
  assign data_o = rx_q;
  assign irq_o  = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_s  <= 3'b111;
      sdi_s <= 2'b00;
    end else begin
      ex_s  <= {ex_s[1:0], sclk_ext_i};
      sdi_s <= {sdi_s[0], sdi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q      <= '0;
      sclk_int_q <= 1'b1;
    end else if (!run) begin
      div_q      <= '0;
      sclk_int_q <= 1'b1;
    end else if (tick) begin
      div_q      <= '0;
      sclk_int_q <= ~sclk_int_q;
    end else begin
      div_q      <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_WSTART;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (mode_wr_i) begin
      st_q    <= (!ext_clk_sel_i && cont_clk_sel_i) ? ST_CONT : ST_WSTART;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      case (st_q)
        ST_WSTART: if (start_i) begin
          st_q    <= ST_WCLK;
          armed_q <= 1'b1;
        end
        ST_WCLK: begin
          if (start_i) armed_q <= 1'b1;
          if (count_rise) begin
            st_q  <= ST_XFER;
            cnt_q <= CW'(1);
          end
        end
        ST_XFER: if (count_rise) begin
          if (wrap_ev) begin
            st_q    <= ST_WCLK;
            cnt_q   <= '0;
            armed_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      rx_q    <= '0;
      sdo_q   <= 1'b0;
    end else if (count_rise) begin
      shreg_q <= {shreg_q[W-2:0], sdi_s[1]};
      if (wrap_ev) begin
        rx_q  <= {shreg_q[W-2:0], sdi_s[1]};
        sdo_q <= shreg_q[W-2];
      end
    end else if (wr_ok) begin
      shreg_q <= data_i;
      sdo_q   <= data_i[W-1];
    end else if (fall_ev && in_xfer) begin
      sdo_q   <= shreg_q[W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (wrap_ev || (in_xfer && (start_i || mode_wr_i))) irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end
endmodule

// File: rtl/ssp_ctrl_chk.sv
module ssp_ctrl_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          mode_wr_i,
  input logic          irq_clr_i,
  input logic          irq_o,
  input logic          sclk_o,
  input logic [1:0]    st,
  input logic [CW-1:0] cnt
);
  AST_XFER_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |-> (cnt != '0)); // R3
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd2) |-> (cnt == '0)); // R7
  AST_MODE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_i |=> (st == 2'd0 || st == 2'd3)); // R7
  AST_START_MIDBYTE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && st == 2'd2) |=> irq_o); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o); // R8
  AST_WAIT_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && $past(st == 2'd0)) |-> sclk_o); // R10
endmodule

bind ssp_ctrl ssp_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_wr_i(mode_wr_i),
  .irq_clr_i(irq_clr_i), .irq_o(irq_o), .sclk_o(sclk_o),
  .st(st_q), .cnt(cnt_q)
);

// File: tb/ssp_ctrl_tb_top.sv
module ssp_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, mode_wr_i = 0, ext_sel = 0, cont_sel = 0, sclk_ext = 1;
  logic sdi_r = 0, loop_en = 0, data_wr = 0, irq_clr = 0;
  logic [7:0] data_in = 0;
  logic sclk_o, sdo_o, irq_o, sdi;
  logic [7:0] data_o;
  int rise_cnt = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  assign sdi = loop_en ? sdo_o : sdi_r;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge sclk_o) rise_cnt++;

  ssp_ctrl #(.W(8), .DIV(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_wr_i(mode_wr_i),
    .ext_clk_sel_i(ext_sel), .cont_clk_sel_i(cont_sel), .sclk_ext_i(sclk_ext),
    .sclk_o(sclk_o), .sdi_i(sdi), .sdo_o(sdo_o), .data_wr_i(data_wr),
    .data_i(data_in), .data_o(data_o), .irq_o(irq_o), .irq_clr_i(irq_clr)
  );

  typedef struct { string req; int kind; int val; } item_t;
  item_t q[$];

  task automatic expect_val(string req, int kind, int val);
    item_t it;
    it.req = req; it.kind = kind; it.val = val;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      bit ok;
      it = q.pop_front();
      case (it.kind)
        0: act = int'(irq_o);
        1: act = int'(data_o);
        2: act = int'(sdo_o);
        3: act = int'(sclk_o);
        default: act = rise_cnt;
      endcase
      ok = (it.kind == 5) ? (act >= it.val) : (act == it.val);
      n_cmp++;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind, act, it.val);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();   start_i = 1;   cyc(1); start_i = 0;   cyc(1); endtask
  task automatic pulse_mode();    mode_wr_i = 1; cyc(1); mode_wr_i = 0; cyc(1); endtask
  task automatic pulse_clr();     irq_clr = 1;   cyc(1); irq_clr = 0;   cyc(1); endtask
  task automatic write_data(logic [7:0] v);
    data_in = v; data_wr = 1; cyc(1); data_wr = 0; cyc(1);
  endtask

  task automatic ext_bits(int from, int to, logic [7:0] b, bit chk, logic [7:0] d);
    for (int i = from; i < to; i++) begin
      sdi_r = b[7-i];
      sclk_ext = 0;
      cyc(HALF);
      if (chk) expect_val("R4", 2, int'(d[7-i]));
      sclk_ext = 1;
      cyc(HALF);
    end
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    expect_val("R1", 0, 0); expect_val("R1", 1, 0);
    expect_val("R1", 2, 0); expect_val("R1", 3, 1);
    cyc(1);

    ext_sel = 1; pulse_mode();
    write_data(8'hA5);
    expect_val("R9", 2, 1);
    ext_bits(0, 8, 8'hFF, 0, 0);
    expect_val("R2", 0, 0); expect_val("R2", 1, 0);
    cyc(1);

    pulse_start();
    ext_bits(0, 8, 8'h3C, 1, 8'hA5);
    expect_val("R3", 0, 1); expect_val("R3", 1, 8'h3C);
    cyc(1);

    pulse_clr();
    expect_val("R8", 0, 0);
    ext_bits(0, 8, 8'hFF, 0, 0);
    expect_val("R5", 0, 0); expect_val("R5", 1, 8'h3C);
    sclk_ext = 0; cyc(HALF);
    expect_val("R12", 3, 1);
    sclk_ext = 1; cyc(HALF);

    write_data(8'h96);
    pulse_start();
    ext_bits(0, 3, 8'h5A, 1, 8'h96);
    pulse_start();
    expect_val("R6", 0, 1);
    cyc(1);
    pulse_clr();
    write_data(8'hFF);
    ext_bits(3, 8, 8'h5A, 1, 8'h96);
    expect_val("R3", 0, 1); expect_val("R9", 1, 8'h5A);
    cyc(1);

    pulse_clr();
    pulse_start();
    ext_bits(0, 4, 8'hC3, 0, 0);
    pulse_mode();
    expect_val("R7", 0, 1);
    cyc(1);
    pulse_clr();
    ext_bits(0, 8, 8'hFF, 0, 0);
    expect_val("R7", 0, 0); expect_val("R7", 1, 8'h5A);
    pulse_start();
    ext_bits(0, 7, 8'h81, 0, 0);
    expect_val("R7", 0, 0);
    ext_bits(7, 8, 8'h81, 0, 0);
    expect_val("R7", 0, 1); expect_val("R7", 1, 8'h81);
    cyc(1);

    pulse_clr();
    ext_sel = 0; cont_sel = 0; pulse_mode();
    write_data(8'hB4);
    loop_en = 1;
    rise_cnt = 0;
    pulse_start();
    cyc(120);
    expect_val("R10", 4, 8); expect_val("R10", 0, 1);
    expect_val("R10", 1, 8'hB4); expect_val("R10", 3, 1);
    cyc(1);

    pulse_clr();
    loop_en = 0;
    cont_sel = 1; pulse_mode();
    rise_cnt = 0;
    cyc(200);
    expect_val("R11", 5, 16); expect_val("R11", 0, 0);
    cyc(1);
    cont_sel = 0; pulse_mode();
    cyc(10);
    rise_cnt = 0;
    cyc(100);
    expect_val("R11", 4, 0); expect_val("R11", 3, 1);
    cyc(3);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule